// File: doc/BRIEF.md
# Two-Thread Shared Decode Arbiter

This block puts one decode stage in front of two hardware threads. Each thread writes opaque instruction tokens into its own short in-order queue inside the block. Every token carries the number of macro-ops it expands to. On each clock the block picks at most one thread. It then takes a run of tokens from the head of that thread's queue and presents them as a decode group of up to four lanes, tagged with the thread number, on that thread's dispatch port.

Tokens that expand to more than two macro-ops take the microcode path. Such a token always decodes alone. It occupies the decoder for as many cycles as its macro-ops need at four per cycle, and while it does so the other thread gets no decode slot. Per-thread dispatch backpressure and a per-thread flush feed into the choice of thread. When both threads have work, the turn alternates strictly between them. When only one thread has work, it gets every cycle.

Top module: `dual_decode_arb`

## Requirements
- R1: A group holds 1 to 4 lanes, filled from lane 0 upward in queue order. `grp_lanes` bit i marks lane i valid, so the mask is always a contiguous run starting at bit 0.
- R2: While both threads are eligible and no microcode beat is in progress, consecutive grants go to different threads.
- R3: A group never mixes threads. `grp_valid` has at most one bit set (bit t for thread t), and `grp_tid` equals the index of that bit.
- R4: When exactly one thread is eligible and no microcode beat is in progress, that thread is granted in that cycle and takes min(4, queued non-microcoded head run) lanes.
- R5: A token whose macro-op count exceeds 2 is microcoded. A group stops in front of a microcoded token that is not at the head, and a microcoded token at the head is granted alone with `grp_mc` = 1.
- R6: A microcoded token with n macro-ops is emitted over ceil(n/4) beats. Each beat has `grp_mc` = 1, min(4, remaining) valid lanes, and the same token in every valid lane. Beats after the first go only to the owning thread, which must have its dispatch port ready. The other thread gets nothing until the last beat has been emitted.
- R7: A thread is eligible only if its queue is non-empty, its `disp_ready` is high and its `flush` is low. No group is presented to a thread whose `disp_ready` is low. If the thread whose turn it is is not eligible, the other eligible thread is served. After any grant that is not a later microcode beat, the turn points at the thread that was not served. Later microcode beats leave the turn unchanged.
- R8: `flush[t]` empties thread t's queue at the end of that cycle, drops any push to thread t in that cycle, and suppresses any group to thread t. If thread t owns a microcode sequence, the sequence is cancelled and the decoder serves either thread from the next cycle.
- R9: After reset both queues are empty, no group is presented, `push_ready` is 2'b11 and the turn points at thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 2 | Per-thread write of one token into the queue |
| push_tok | input | 2x8 | Per-thread token value |
| push_uops | input | 2x5 | Per-thread macro-op count of the token (1 or more) |
| push_ready | output | 2 | Per-thread queue has room |
| flush | input | 2 | Per-thread flush of pending tokens and microcode |
| disp_ready | input | 2 | Per-thread dispatch port can accept a group |
| grp_valid | output | 2 | Group presented to thread t's dispatch port (bit t) |
| grp_tid | output | 1 | Thread number of the current group |
| grp_mc | output | 1 | Current group is a microcode beat |
| grp_lanes | output | 4 | Lane valid mask of the group |
| grp_tok | output | 4x8 | Token in each lane |

## Verification
The assertions assume that every pushed token has a macro-op count of at least one. They also assume that a thread pushes only while its `push_ready` is high, because a full queue silently drops the write. The stimulus keeps to both assumptions: it loads no more than eight tokens per thread, holds `disp_ready` low while it loads so that no groups drain during filling, and uses only counts between 1 and 12. Flush and backpressure are driven only from the bench at the falling edge, and the alternation property only looks one cycle back from a cycle in which reset was already low.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    localparam int NTHR     = 2;
    localparam int LANES    = 4;
    localparam int TOK_W    = 8;
    localparam int UOP_W    = 5;
    localparam int MC_LIMIT = 2;
    localparam int TAKE_W   = $clog2(LANES + 1);

    typedef struct packed {
        logic [TOK_W-1:0] tok;
        logic [UOP_W-1:0] uops;
    } instr_t;

    typedef instr_t [LANES-1:0] window_t;

    // Thermometer mask with the low n lanes set.
    function automatic logic [LANES-1:0] lane_mask(input logic [TAKE_W-1:0] n);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i] = (TAKE_W'(i) < n);
        end
        return m;
    endfunction

    // Macro-ops emitted in one beat out of the remaining count.
    function automatic logic [TAKE_W-1:0] beat_of(input logic [UOP_W-1:0] rem);
        if (rem > UOP_W'(LANES)) begin
            return TAKE_W'(LANES);
        end
        return TAKE_W'(rem);
    endfunction

    function automatic logic is_mc(input logic [UOP_W-1:0] uops);
        return uops > UOP_W'(MC_LIMIT);
    endfunction

endpackage

// File: rtl/dsa_thread_queue.sv
module dsa_thread_queue
    import dsa_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push_valid,
    input  instr_t            push_data,
    output logic              push_ready,
    input  logic [TAKE_W-1:0] pop_n,
    output window_t           win,
    output logic [TAKE_W-1:0] win_cnt
);
    // DEPTH must be a power of two and at least LANES.
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    instr_t            mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;
    logic              push_fire;

    assign push_ready = (count < CNT_W'(DEPTH));
    assign push_fire  = push_valid && push_ready && !flush;

    always_ff @(posedge clk) begin
        if (push_fire) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_fire) begin
                wr_ptr <= wr_ptr + PTR_W'(1);
            end
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            count  <= count + CNT_W'(push_fire) - CNT_W'(pop_n);
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_win
        assign win[i] = mem[rd_ptr + PTR_W'(i)];
    end

    assign win_cnt = (count > CNT_W'(LANES)) ? TAKE_W'(LANES) : TAKE_W'(count);

    // R1: the arbiter never consumes more tokens than the window shows
    a_r1_pop_bound: assert property (@(posedge clk) disable iff (rst)
        pop_n <= win_cnt);

    // R8: a flushed queue shows nothing on the following cycle
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (win_cnt == '0));

endmodule

// File: rtl/dsa_group_former.sv
module dsa_group_former
    import dsa_pkg::*;
(
    input  window_t           win,
    input  logic [TAKE_W-1:0] win_cnt,
    output logic [TAKE_W-1:0] take_n,
    output logic              head_mc
);
    logic stop;

    always_comb begin
        head_mc = (win_cnt != '0) && is_mc(win[0].uops);
        take_n  = '0;
        stop    = 1'b0;
        if (head_mc) begin
            take_n = TAKE_W'(1);
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (!stop && (TAKE_W'(i) < win_cnt) && !is_mc(win[i].uops)) begin
                    take_n = TAKE_W'(i + 1);
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dual_decode_arb.sv
module dual_decode_arb
    import dsa_pkg::*;
#(
    parameter int QDEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NTHR-1:0]             push_valid,
    input  logic [NTHR-1:0][TOK_W-1:0]  push_tok,
    input  logic [NTHR-1:0][UOP_W-1:0]  push_uops,
    output logic [NTHR-1:0]             push_ready,
    input  logic [NTHR-1:0]             flush,
    input  logic [NTHR-1:0]             disp_ready,
    output logic [NTHR-1:0]             grp_valid,
    output logic                        grp_tid,
    output logic                        grp_mc,
    output logic [LANES-1:0]            grp_lanes,
    output logic [LANES-1:0][TOK_W-1:0] grp_tok
);
    window_t           win     [NTHR];
    logic [TAKE_W-1:0] win_cnt [NTHR];
    logic [TAKE_W-1:0] take_n  [NTHR];
    logic [TAKE_W-1:0] pop_n   [NTHR];
    logic [NTHR-1:0]   head_mc;
    logic [NTHR-1:0]   elig;
    instr_t            push_d  [NTHR];

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign push_d[t] = {push_tok[t], push_uops[t]};
        assign elig[t]   = (win_cnt[t] != '0) && disp_ready[t] && !flush[t];

        dsa_thread_queue #(.DEPTH(QDEPTH)) u_queue (
            .clk        (clk),
            .rst        (rst),
            .flush      (flush[t]),
            .push_valid (push_valid[t]),
            .push_data  (push_d[t]),
            .push_ready (push_ready[t]),
            .pop_n      (pop_n[t]),
            .win        (win[t]),
            .win_cnt    (win_cnt[t])
        );

        dsa_group_former u_former (
            .win     (win[t]),
            .win_cnt (win_cnt[t]),
            .take_n  (take_n[t]),
            .head_mc (head_mc[t])
        );
    end

    // Arbitration and microcode state
    logic              turn;
    logic              mc_active;
    logic              mc_tid;
    logic [TOK_W-1:0]  mc_tok;
    logic [UOP_W-1:0]  mc_left;

    logic              pick;
    logic              gnt_any;
    logic              start_mc;
    logic              hold_beat;
    logic [TAKE_W-1:0] hold_n;
    logic [UOP_W-1:0]  head_uops;

    always_comb begin
        pick      = 1'b0;
        gnt_any   = 1'b0;
        start_mc  = 1'b0;
        hold_beat = 1'b0;
        hold_n    = beat_of(mc_left);
        head_uops = '0;
        grp_valid = '0;
        grp_tid   = 1'b0;
        grp_mc    = 1'b0;
        grp_lanes = '0;
        grp_tok   = '0;
        for (int t = 0; t < NTHR; t++) begin
            pop_n[t] = '0;
        end

        if (mc_active) begin
            if (!flush[mc_tid] && disp_ready[mc_tid]) begin
                hold_beat         = 1'b1;
                grp_valid[mc_tid] = 1'b1;
                grp_tid           = mc_tid;
                grp_mc            = 1'b1;
                grp_lanes         = lane_mask(hold_n);
                for (int i = 0; i < LANES; i++) begin
                    grp_tok[i] = grp_lanes[i] ? mc_tok : '0;
                end
            end
        end else begin
            if (elig[turn]) begin
                pick    = turn;
                gnt_any = 1'b1;
            end else if (elig[~turn]) begin
                pick    = ~turn;
                gnt_any = 1'b1;
            end
            if (gnt_any) begin
                grp_valid[pick] = 1'b1;
                grp_tid         = pick;
                pop_n[pick]     = take_n[pick];
                head_uops       = win[pick][0].uops;
                if (head_mc[pick]) begin
                    start_mc  = 1'b1;
                    grp_mc    = 1'b1;
                    grp_lanes = lane_mask(beat_of(head_uops));
                    for (int i = 0; i < LANES; i++) begin
                        grp_tok[i] = grp_lanes[i] ? win[pick][0].tok : '0;
                    end
                end else begin
                    grp_lanes = lane_mask(take_n[pick]);
                    for (int i = 0; i < LANES; i++) begin
                        grp_tok[i] = grp_lanes[i] ? win[pick][i].tok : '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            turn      <= 1'b0;
            mc_active <= 1'b0;
            mc_tid    <= 1'b0;
            mc_tok    <= '0;
            mc_left   <= '0;
        end else if (mc_active) begin
            if (flush[mc_tid]) begin
                mc_active <= 1'b0;
            end else if (hold_beat) begin
                mc_left <= mc_left - UOP_W'(hold_n);
                if (mc_left <= UOP_W'(LANES)) begin
                    mc_active <= 1'b0;
                end
            end
        end else if (gnt_any) begin
            turn <= ~pick;
            if (start_mc && (head_uops > UOP_W'(LANES))) begin
                mc_active <= 1'b1;
                mc_tid    <= pick;
                mc_tok    <= win[pick][0].tok;
                mc_left   <= head_uops - UOP_W'(LANES);
            end
        end
    end

    // R3: one thread per group, tag agrees with the port
    a_r3_one_thread: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grp_valid) && ((grp_valid == '0) || grp_valid[grp_tid]));

    // R2: back-to-back grants under dual load go to different threads
    a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !mc_active && (&elig) &&
         $past(!mc_active && (&elig) && (|grp_valid) && !grp_mc))
        |-> (grp_valid != $past(grp_valid)));

    // R4: a lone eligible thread is served in that cycle
    a_r4_full_rate: assert property (@(posedge clk) disable iff (rst)
        (!mc_active && ($countones(elig) == 1)) |-> (grp_valid == elig));

    // R6: later microcode beats never reach the other thread
    a_r6_hold_exclusive: assert property (@(posedge clk) disable iff (rst)
        mc_active |-> !grp_valid[~mc_tid]);

    // R7: no group to a port that is not ready
    a_r7_ready_only: assert property (@(posedge clk) disable iff (rst)
        (grp_valid & ~disp_ready) == '0);

    // R8: a flushed thread receives nothing in the flush cycle
    a_r8_flush_silent: assert property (@(posedge clk) disable iff (rst)
        (grp_valid & flush) == '0);

endmodule

// File: tb/test_dual_decode_arb.sv
`timescale 1ns/1ps
module test_dual_decode_arb;
    import dsa_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst;
    logic [NTHR-1:0]             push_valid;
    logic [NTHR-1:0][TOK_W-1:0]  push_tok;
    logic [NTHR-1:0][UOP_W-1:0]  push_uops;
    logic [NTHR-1:0]             push_ready;
    logic [NTHR-1:0]             flush;
    logic [NTHR-1:0]             disp_ready;
    logic [NTHR-1:0]             grp_valid;
    logic                        grp_tid;
    logic                        grp_mc;
    logic [LANES-1:0]            grp_lanes;
    logic [LANES-1:0][TOK_W-1:0] grp_tok;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_decode_arb i_dual_decode_arb (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_tok(push_tok),
        .push_uops(push_uops), .push_ready(push_ready), .flush(flush),
        .disp_ready(disp_ready), .grp_valid(grp_valid), .grp_tid(grp_tid),
        .grp_mc(grp_mc), .grp_lanes(grp_lanes), .grp_tok(grp_tok)
    );

    // Row: [15:14] disp_ready, [13:12] expected grp_valid,
    //      [11:8] expected lanes, [7:0] token in lane 0 (lane i holds +i)
    localparam logic [15:0] TBL [6] = '{
        16'hDF10, 16'hEF20, 16'hAF24, 16'hDF14, 16'hC000, 16'h0000
    };

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_grp(input string req, input logic [1:0] ev,
                           input logic [3:0] el, input bit emc,
                           input logic [7:0] et);
        chk(grp_valid == ev, {req, " grp_valid"}, 32'(grp_valid), 32'(ev));
        if (ev != 2'b00) begin
            chk(grp_lanes == el, {req, " lanes"}, 32'(grp_lanes), 32'(el));
            chk(grp_mc == emc, {req, " mc"}, 32'(grp_mc), 32'(emc));
            chk(grp_tid == ev[1], {req, " R3 tid"}, 32'(grp_tid), 32'(ev[1]));
            for (int i = 0; i < LANES; i++) begin
                if (el[i]) begin
                    chk(grp_tok[i] == (emc ? et : et + 8'(i)), {req, " tok"},
                        32'(grp_tok[i]), 32'(emc ? et : et + 8'(i)));
                end
            end
        end
    endtask

    task automatic step;
        @(negedge clk);
        push_valid = '0;
        flush      = '0;
    endtask

    task automatic do_reset;
        rst        = 1'b1;
        push_valid = '0;
        flush      = '0;
        disp_ready = '0;
        push_tok   = '0;
        push_uops  = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input int t, input logic [7:0] tok, input logic [4:0] u);
        step();
        disp_ready    = '0;
        push_valid[t] = 1'b1;
        push_tok[t]   = tok;
        push_uops[t]  = u;
    endtask

    task automatic load_both(input logic [7:0] t0, input logic [4:0] u0,
                             input logic [7:0] t1, input logic [4:0] u1);
        load(0, t0, u0);
        push_valid[1] = 1'b1;
        push_tok[1]   = t1;
        push_uops[1]  = u1;
    endtask

    task automatic cyc(input logic [1:0] rdy);
        step();
        disp_ready = rdy;
        #1;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R9: reset state
        do_reset();
        cyc(2'b11);
        chk(grp_valid == 2'b00, "R9 no group after reset", 32'(grp_valid), 0);
        chk(push_ready == 2'b11, "R9 push_ready", 32'(push_ready), 3);

        // Table: dual load of single-op tokens, R2 R4 R7 R1
        do_reset();
        for (int k = 0; k < 8; k++) begin
            load_both(8'h10 + 8'(k), 5'd1, 8'h20 + 8'(k), 5'd1);
        end
        for (int r = 0; r < 6; r++) begin
            cyc(TBL[r][15:14]);
            chk_grp("R2 R7 table", TBL[r][13:12], TBL[r][11:8], 1'b0, TBL[r][7:0]);
        end

        // R4: single load uses full width on consecutive cycles
        do_reset();
        for (int k = 0; k < 8; k++) begin
            load(0, 8'h71 + 8'(k), 5'd1);
        end
        cyc(2'b11); chk_grp("R4 first", 2'b01, 4'hF, 1'b0, 8'h71);
        cyc(2'b11); chk_grp("R4 second", 2'b01, 4'hF, 1'b0, 8'h75);
        cyc(2'b11); chk_grp("R4 drained", 2'b00, 4'h0, 1'b0, 8'h00);

        // R5 R6 R7: group boundary at microcode, hold blocks other thread
        do_reset();
        load_both(8'h31, 5'd1, 8'h41, 5'd1);
        load_both(8'h32, 5'd2, 8'h42, 5'd1);
        load_both(8'h33, 5'd9, 8'h43, 5'd1);
        load_both(8'h34, 5'd1, 8'h44, 5'd1);
        load(1, 8'h45, 5'd1);
        load(1, 8'h46, 5'd1);
        cyc(2'b11); chk_grp("R5 stop before mc", 2'b01, 4'h3, 1'b0, 8'h31);
        cyc(2'b11); chk_grp("R2 other thread", 2'b10, 4'hF, 1'b0, 8'h41);
        cyc(2'b11); chk_grp("R5 mc start", 2'b01, 4'hF, 1'b1, 8'h33);
        cyc(2'b11); chk_grp("R6 hold beat", 2'b01, 4'hF, 1'b1, 8'h33);
        cyc(2'b11); chk_grp("R6 last beat", 2'b01, 4'h1, 1'b1, 8'h33);
        cyc(2'b11); chk_grp("R7 turn after mc", 2'b10, 4'h3, 1'b0, 8'h45);
        cyc(2'b11); chk_grp("R5 after mc", 2'b01, 4'h1, 1'b0, 8'h34);
        cyc(2'b11); chk_grp("R6 done", 2'b00, 4'h0, 1'b0, 8'h00);

        // R5 R6: three ops is microcoded but fits in one beat
        do_reset();
        load(0, 8'h81, 5'd3);
        load(0, 8'h82, 5'd1);
        cyc(2'b11); chk_grp("R6 single beat", 2'b01, 4'h7, 1'b1, 8'h81);
        cyc(2'b11); chk_grp("R5 next group", 2'b01, 4'h1, 1'b0, 8'h82);

        // R8: flush during a hold cancels it and drops the push
        do_reset();
        load_both(8'h51, 5'd12, 8'h61, 5'd1);
        load(1, 8'h62, 5'd1);
        cyc(2'b11); chk_grp("R8 mc start", 2'b01, 4'hF, 1'b1, 8'h51);
        step();
        disp_ready   = 2'b11;
        flush[0]     = 1'b1;
        push_valid[0] = 1'b1;
        push_tok[0]  = 8'h52;
        push_uops[0] = 5'd1;
        #1;
        chk_grp("R8 flush cycle silent", 2'b00, 4'h0, 1'b0, 8'h00);
        cyc(2'b11); chk_grp("R8 released", 2'b10, 4'h3, 1'b0, 8'h61);
        cyc(2'b11); chk_grp("R8 push dropped", 2'b00, 4'h0, 1'b0, 8'h00);

        // R8: flush empties a waiting queue
        do_reset();
        load(1, 8'h91, 5'd1);
        load(1, 8'h92, 5'd1);
        load(1, 8'h93, 5'd1);
        step();
        disp_ready = 2'b00;
        flush[1]   = 1'b1;
        #1;
        chk(grp_valid == 2'b00, "R8 flush cycle", 32'(grp_valid), 0);
        cyc(2'b11);
        chk(grp_valid == 2'b00, "R8 queue cleared", 32'(grp_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule